// File: doc/BRIEF.md
# Wide Timestamp Counter with Snapshot Read

A free-running timestamp counter, 40 bits wide by default, read through a 32-bit register port. It advances by one on each cycle in which the external tick enable is high and counting is switched on. It never raises an interrupt. Counting is switched on by a control bit that lives in the same register that holds the upper part of the count.

Software reads the full count in two accesses. It reads the low word first. That read also copies the upper counter bits into a holding register in the same clock cycle. It then reads the high register, which returns that held copy, so the two halves always belong to the same instant even while the counter keeps moving. Reads are combinational: `rdata_o` is valid in the cycle of `rd_i`, and any side effect of the read takes hold at the next clock edge.

Top module: `stamp_timer`

## Requirements
- R1: After reset the count is zero, counting is disabled and the held upper part is zero. Both registers read as zero.
- R2: A read at byte offset 0x60 returns count bits [DATA_W-1:0] as they stand in that cycle.
- R3: A read at offset 0x60 loads count bits [CNT_W-1:DATA_W] into the holding register at the clock edge that ends the read. The value loaded is the one from the same cycle as the returned low word.
- R4: A read at offset 0x64 returns the held upper part in bits [CNT_W-DATA_W-1:0] and the enable state in bit EN_BIT (8 by default). All other bits read as zero.
- R5: The holding register changes only on a low-word read. Counting, high-register reads and writes leave it unchanged.
- R6: A write at offset 0x64 sets the enable to wdata_i[EN_BIT] from the next cycle on. While enabled, the count rises by exactly one per cycle with tick_i high.
- R7: With the enable clear, or with tick_i low, the count holds its value.
- R8: One tick at the all-ones count wraps the count to zero.
- R9: A write to the low word or to an unmapped offset has no effect. Reads of unmapped offsets, and rdata_o whenever rd_i is low, return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count tick enable, one step per high cycle |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle of rd_i |

## Verification
The assertions assume that every strobe is a synchronous single-cycle request. They also assume that `addr_i` and `wdata_i` are stable from the falling edge through the next rising edge. A read that coincides with a write or a tick is taken as legal, and the snapshot then sees the count from before the edge. The bench changes all inputs only at falling edges and mixes simultaneous reads, writes and ticks in a random phase. A second instance with a 12-bit count and an 8-bit data path makes the wrap reachable within a few thousand ticks.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/stamp_count.sv
module stamp_count #(
  parameter int CNT_W = 40,
  parameter int SEG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int NSEG = (CNT_W + SEG_W - 1) / SEG_W;

  logic [CNT_W-1:0] cnt_q;
  logic [NSEG:0]    carry;

  assign carry[0] = en_i & tick_i;

  // segmented increment: each segment steps when all lower ones are full
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int LO = g * SEG_W;
    localparam int HI = (LO + SEG_W > CNT_W) ? CNT_W - 1 : LO + SEG_W - 1;
    localparam int SW = HI - LO + 1;

    assign carry[g+1] = carry[g] & (&cnt_q[HI:LO]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q[HI:LO] <= '0;
      else if (carry[g]) cnt_q[HI:LO] <= cnt_q[HI:LO] + SW'(1);
    end
  end

  logic unused_carry;
  assign unused_carry = carry[NSEG];

  assign cnt_o = cnt_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && tick_i) |=> $stable(cnt_o));
  p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !(&cnt_o)) |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && (&cnt_o)) |=> cnt_o == '0);
endmodule

// File: rtl/stamp_snap.sv
module stamp_snap #(
  parameter int HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            snap_i,
  input  logic [HI_W-1:0] cnt_hi_i,
  output logic [HI_W-1:0] hi_o
);
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_q <= '0;
    else if (snap_i) hi_q <= cnt_hi_i;
  end

  assign hi_o = hi_q;

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> hi_o == $past(cnt_hi_i));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(hi_o));
endmodule

// File: rtl/stamp_regs.sv
module stamp_regs
  import stamp_pkg::*;
#(
  parameter int                DATA_W = 32,
  parameter int                ADDR_W = 8,
  parameter int                HI_W   = 8,
  parameter int                EN_BIT = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = ADDR_W'('h60),
  parameter logic [ADDR_W-1:0] HI_OFS = ADDR_W'('h64)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_lo_i,
  input  logic [HI_W-1:0]   hi_i,
  output logic              snap_o,
  output logic              en_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e          sel;
  logic              en_q;
  logic [DATA_W-1:0] hi_word;

  always_comb begin
    if (addr_i == LO_OFS)      sel = SEL_LO;
    else if (addr_i == HI_OFS) sel = SEL_HI;
    else                       sel = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      en_q <= 1'b0;
    else if (wr_i && sel == SEL_HI)   en_q <= wdata_i[EN_BIT];
  end

  always_comb begin
    hi_word             = '0;
    hi_word[HI_W-1:0]   = hi_i;
    hi_word[EN_BIT]     = en_q;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel)
        SEL_LO:  rdata_o = cnt_lo_i;
        SEL_HI:  rdata_o = hi_word;
        default: rdata_o = '0;
      endcase
    end
  end

  assign snap_o = rd_i && (sel == SEL_LO);
  assign en_o   = en_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  p_en_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == HI_OFS) |=> en_o == $past(wdata_i[EN_BIT]));
  p_en_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == HI_OFS) |=> $stable(en_o));
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || (addr_i != LO_OFS && addr_i != HI_OFS)) |-> rdata_o == '0);
  p_hi_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == HI_OFS) |->
      (rdata_o[HI_W-1:0] == hi_i && rdata_o[EN_BIT] == en_o &&
       $countones(rdata_o) == $countones(hi_i) + (en_o ? 1 : 0)));
endmodule

// File: rtl/stamp_timer.sv
module stamp_timer #(
  parameter int                CNT_W  = 40,
  parameter int                DATA_W = 32,
  parameter int                ADDR_W = 8,
  parameter int                SEG_W  = 8,
  parameter int                EN_BIT = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = ADDR_W'('h60),
  parameter logic [ADDR_W-1:0] HI_OFS = ADDR_W'('h64)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  hi_held;
  logic             snap;
  logic             en;

  stamp_count #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .tick_i (tick_i),
    .cnt_o  (cnt)
  );

  stamp_snap #(.HI_W(HI_W)) u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .snap_i   (snap),
    .cnt_hi_i (cnt[CNT_W-1:DATA_W]),
    .hi_o     (hi_held)
  );

  stamp_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .HI_W   (HI_W),
    .EN_BIT (EN_BIT),
    .LO_OFS (LO_OFS),
    .HI_OFS (HI_OFS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_lo_i (cnt[DATA_W-1:0]),
    .hi_i     (hi_held),
    .snap_o   (snap),
    .en_o     (en),
    .rdata_o  (rdata_o)
  );

  p_lo_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == LO_OFS) |-> rdata_o == cnt[DATA_W-1:0]);
endmodule

// File: tb/stamp_timer_bench.sv
`timescale 1ns/1ps
module stamp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_w;
  logic [7:0]  rdata_n;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  stamp_timer u_stamp_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_w)
  );

  // narrow instance: 12-bit count, 8-bit data, enable at bit 4
  stamp_timer #(.CNT_W(12), .DATA_W(8), .EN_BIT(4)) u_stamp_timer_n (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata[7:0]), .rdata_o(rdata_n)
  );

  // reference model state: [0] wide, [1] narrow
  longint unsigned m_cnt [2];
  longint unsigned m_hi  [2];
  bit              m_en  [2];
  int              dw    [2] = '{32, 12};
  int              cw    [2] = '{40, 12};
  int              ebit  [2] = '{8, 4};

  initial begin
    dw[1] = 8;
  end

  function automatic longint unsigned expect_rd(int k);
    if (!rd) return 0;
    if (addr == 8'h60) return m_cnt[k] & ((64'd1 << dw[k]) - 1);
    if (addr == 8'h64) return (longint'(m_en[k]) << ebit[k]) | m_hi[k];
    return 0;
  endfunction

  task automatic check(string tag, longint unsigned act, longint unsigned exp, int k);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s inst%0d: actual %h expected %h", tag, k, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic w, input logic [7:0] a,
                      input logic [31:0] wd, input logic tk, input string tag);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = wd; tick = tk;
    #1;
    check(tag, longint'(rdata_w), expect_rd(0), 0);
    check(tag, longint'(rdata_n), expect_rd(1), 1);
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      bit en_now = m_en[k];
      if (rd && addr == 8'h60) m_hi[k] = m_cnt[k] >> dw[k];
      if (en_now && tick) m_cnt[k] = (m_cnt[k] + 1) & ((64'd1 << cw[k]) - 1);
      if (wr && addr == 8'h64) m_en[k] = wdata[ebit[k]];
    end
  endtask

  function automatic string tag_for(logic r, logic [7:0] a);
    if (r && a == 8'h60) return "R2";
    if (r && a == 8'h64) return "R4";
    return "R9";
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_hi[k] = 0; m_en[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step(1, 0, 8'h64, 0, 0, "R1");
    step(1, 0, 8'h60, 0, 0, "R1");
    // R7: ticks while disabled
    repeat (5) step(0, 0, 8'h00, 0, 1, "R7");
    step(1, 0, 8'h60, 0, 0, "R7");
    // R6: enable both instances (bit 8 and bit 4) together with a tick
    step(0, 1, 8'h64, 32'h110, 1, "R6");
    repeat (7) step(0, 0, 8'h00, 0, 1, "R6");
    step(1, 0, 8'h60, 0, 0, "R6");
    step(1, 0, 8'h64, 0, 0, "R6");
    // R7: enabled but no tick
    repeat (4) step(0, 0, 8'h00, 0, 0, "R7");
    step(1, 0, 8'h60, 0, 0, "R7");
    // R3: low read with tick in same cycle, then high read
    repeat (300) step(0, 0, 8'h00, 0, 1, "R3");
    step(1, 0, 8'h60, 0, 1, "R3");
    step(1, 0, 8'h64, 0, 1, "R3");
    // R5: counter runs, high reads and writes do not move the held part
    repeat (400) step(0, 0, 8'h00, 0, 1, "R5");
    step(1, 1, 8'h64, 32'h110, 1, "R5");
    step(1, 0, 8'h64, 0, 1, "R5");
    // R9: writes to low word and unmapped offsets
    step(0, 1, 8'h60, 32'hFFFF_FFFF, 1, "R9");
    step(0, 1, 8'h68, 32'h0, 1, "R9");
    step(1, 0, 8'h68, 0, 1, "R9");
    step(1, 0, 8'h64, 0, 0, "R9");
    step(1, 0, 8'h60, 0, 0, "R9");
    // R6: disable, then ticks must not count
    step(0, 1, 8'h64, 32'h0, 1, "R6");
    repeat (5) step(0, 0, 8'h00, 0, 1, "R7");
    step(1, 0, 8'h60, 0, 0, "R7");
    // random mix of reads, writes and ticks
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic       r, w;
      int         s = $urandom_range(0, 3);
      a = (s == 0) ? 8'h60 : (s == 1) ? 8'h64 : (s == 2) ? 8'h68 : 8'h00;
      r = $urandom_range(0, 1);
      w = ($urandom_range(0, 7) == 0);
      step(r, w, a, (($urandom_range(0, 3) != 0) ? 32'h110 : 32'h0) | ($urandom & 32'hFFFF_FEEF),
           $urandom_range(0, 1), tag_for(r, a));
    end
    // R8: wrap on narrow instance
    step(0, 1, 8'h64, 32'h110, 0, "R8");
    while (m_cnt[1] != 64'hFFF) step(0, 0, 8'h00, 0, 1, "R8");
    step(1, 0, 8'h60, 0, 1, "R8");
    step(1, 0, 8'h64, 0, 0, "R8");
    step(1, 0, 8'h60, 0, 0, "R8");
    step(1, 0, 8'h64, 0, 0, "R8");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule